// File: doc/BRIEF.md
# Egress Descriptor Ring Pointer Tracker

This block keeps the producer and consumer pointers for a small set of egress descriptor rings. Software hands new descriptors to a ring with one 64-bit store. The store carries the tail index as it stood before the post, the number of descriptors added and a generation bit. The block folds these into a new tail and a tail generation for that ring, and wraps the tail at the ring's power-of-two size. A post may therefore run across the end of the ring.

A stand-in for the descriptor fetcher walks each ring's head toward its tail, one entry per cycle while its grant is high. The head generation toggles each time the head wraps. A completion input counts finished descriptors per ring. A 64-bit load returns the head, the rolling completion count and the head generation. Software uses that reply to judge ring fill and to decide when buffers may be reused.

Top module: `desc_ring_tracker`

## Requirements
- R1: After reset every ring has head, tail, both generations and the completion count at zero, so a load of any ring returns all zeros.
- R2: A store or load is addressed to a ring only when address bits [28:26] equal 5 and the ring number in address bits [8:3] is below NUM_RINGS. A store that misses on either test changes nothing.
- R3: Store data gives the pre-post tail in bits [15:0], the descriptor count in bits [31:16] and the generation in bit 32. The index is masked to the ring size, the new tail is (index + count) modulo the ring size, and the fetcher stops when the head reaches it.
- R4: A count of up to the full ring size is accepted, and a post that crosses the end of the ring sets the tail generation to the inverse of the posted bit. A post of exactly one ring size makes the fetcher make one full lap. A store whose count exceeds the ring size is ignored.
- R5: A store with a count of zero reloads the ring's tail and tail generation from the written index and bit. Fetching then restarts toward that tail, whatever the tail held before.
- R6: The head advances by exactly one per cycle while the ring's fetch grant is high and the head or head generation differs from the tail. On a wrap from the last entry to zero the head generation toggles. With the grant low the head holds.
- R7: A load returns its data with rd_valid one cycle after rd_en. The data holds the head in bits [15:0], the completion count in bits [31:16] and the head generation in bit 32, with all other bits zero. A load to a ring that is not addressed (R2) returns zero.
- R8: Each cycle with done_valid high adds one to the completion count of the ring named by done_ring. The count wraps from 65535 to 0.
- R9: The completion count of a ring clears when that ring's flush input falls from 1 to 0. The clear wins over a completion in the same cycle, and a held-high flush alone does not clear it.
- R10: Rings are independent, and each ring takes its own size from the RING_LOG2S parameter (default sizes 8, 4, 16 and 2 for rings 0 to 3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Post store strobe |
| wr_addr | input | 40 | Post store address |
| wr_data | input | 64 | Post store data: index, count, generation |
| rd_en | input | 1 | Progress load strobe |
| rd_addr | input | 40 | Progress load address |
| rd_valid | output | 1 | Load data valid, one cycle after rd_en |
| rd_data | output | 64 | Head, completion count and head generation |
| fetch_go | input | NUM_RINGS (4) | Per-ring grant for the fetcher stand-in |
| done_valid | input | 1 | One descriptor completed |
| done_ring | input | 6 | Ring of the completed descriptor |
| flush | input | NUM_RINGS (4) | Per-ring flush bit; its falling edge clears the count |

## Verification
The bench posts across the wrap point and posts a full ring. It checks that the head runs one whole lap and toggles the generation, where a design that compared only indices would treat the ring as empty and stay put. It sends a count larger than the ring and a store to the wrong region, both of which must leave the head unmoved. It also sends a zero-count wake-up and an index with bits above the ring mask, which a design without masking would chase past the ring. It pauses the fetch grant to pin down the one-step-per-cycle rate. It drives 65537 completions to see the count wrap, and lines a completion up with the flush falling edge, where a design with the wrong priority would read 1 instead of 0.

// File: rtl/drt_pkg.sv
package drt_pkg;

    localparam int IDX_W       = 16;
    localparam int CNT_W       = 16;
    localparam int ADDR_W      = 40;
    localparam int DATA_W      = 64;
    localparam int RING_SEL_W  = 6;
    localparam int RING_LSB    = 3;
    localparam int REGION_LSB  = 26;
    localparam int REGION_W    = 3;
    localparam int REGION_POST = 5;
    localparam int CNT_LSB     = 16;
    localparam int GEN_BIT     = 32;

    typedef struct packed {
        logic [IDX_W-1:0] head;
        logic [IDX_W-1:0] tail;
        logic             hgen;
        logic             tgen;
        logic [CNT_W-1:0] done_cnt;
        logic             flush_seen;
    } slot_state_t;

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
    } rd_state_t;

    function automatic logic region_hit(input logic [ADDR_W-1:0] a);
        return a[REGION_LSB +: REGION_W] == REGION_W'(REGION_POST);
    endfunction

endpackage

// File: rtl/drt_post_decode.sv
module drt_post_decode
    import drt_pkg::*;
#(
    parameter int NUM_RINGS = 4
) (
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [DATA_W-1:0]    wr_data,
    output logic [NUM_RINGS-1:0] post_vld,
    output logic [IDX_W-1:0]     post_idx,
    output logic [CNT_W-1:0]     post_cnt,
    output logic                 post_gen
);

    logic [RING_SEL_W-1:0] ring_sel;
    logic                  addr_ok;

    always_comb begin
        ring_sel = wr_addr[RING_LSB +: RING_SEL_W];
        addr_ok  = wr_en && region_hit(wr_addr);
        post_idx = wr_data[IDX_W-1:0];
        post_cnt = wr_data[CNT_LSB +: CNT_W];
        post_gen = wr_data[GEN_BIT];
    end

    for (genvar i = 0; i < NUM_RINGS; i++) begin : g_sel
        assign post_vld[i] = addr_ok && (ring_sel == RING_SEL_W'(i));
    end

endmodule

// File: rtl/drt_ring_slot.sv
module drt_ring_slot
    import drt_pkg::*;
#(
    parameter int LOG2 = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             post_vld,
    input  logic [IDX_W-1:0] post_idx,
    input  logic [CNT_W-1:0] post_cnt,
    input  logic             post_gen,
    input  logic             fetch_go,
    input  logic             done_hit,
    input  logic             flush_req,
    output logic [IDX_W-1:0] head,
    output logic [CNT_W-1:0] done_cnt,
    output logic             gen
);

    localparam logic [IDX_W:0]   SIZE = (IDX_W+1)'(1) << LOG2;
    localparam logic [IDX_W-1:0] MASK = IDX_W'(SIZE - 1'b1);

    slot_state_t st_d, st_q;

    logic [IDX_W-1:0] idx_m;
    logic [IDX_W:0]   sum;
    logic             oversize;
    logic             wrap;
    logic [IDX_W-1:0] tail_new;
    logic             pending;
    logic             clear;

    always_comb begin
        st_d     = st_q;
        idx_m    = post_idx & MASK;
        sum      = {1'b0, idx_m} + {1'b0, post_cnt};
        oversize = {1'b0, post_cnt} > SIZE;
        wrap     = sum >= SIZE;
        tail_new = wrap ? IDX_W'(sum - SIZE) : IDX_W'(sum);
        pending  = (st_q.head != st_q.tail) || (st_q.hgen != st_q.tgen);
        clear    = st_q.flush_seen && !flush_req;

        if (post_vld && !oversize) begin
            st_d.tail = tail_new;
            st_d.tgen = post_gen ^ wrap;
        end

        if (fetch_go && pending) begin
            if (st_q.head == MASK) begin
                st_d.head = '0;
                st_d.hgen = ~st_q.hgen;
            end else begin
                st_d.head = st_q.head + 1'b1;
            end
        end

        if (clear) begin
            st_d.done_cnt = '0;
        end else if (done_hit) begin
            st_d.done_cnt = st_q.done_cnt + 1'b1;
        end

        st_d.flush_seen = flush_req;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign head     = st_q.head;
    assign done_cnt = st_q.done_cnt;
    assign gen      = st_q.hgen;

    // R1: reset leaves every pointer and the count at zero
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (st_q.head == '0 && st_q.tail == '0 && st_q.done_cnt == '0));

    // R2: no accepted post, no tail movement
    a_r2_tail_hold: assert property (@(posedge clk) disable iff (rst)
        !post_vld |=> $stable(st_q.tail) && $stable(st_q.tgen));

    // R4: a count above the ring size is dropped
    a_r4_no_oversize: assert property (@(posedge clk) disable iff (rst)
        (post_vld && oversize) |=> $stable(st_q.tail));

    // R6: head holds without a grant or with nothing to fetch
    a_r6_head_hold: assert property (@(posedge clk) disable iff (rst)
        (!fetch_go || !pending) |=> $stable(st_q.head) && $stable(st_q.hgen));

    // R9: falling flush clears the count
    a_r9_flush_clear: assert property (@(posedge clk) disable iff (rst)
        (st_q.flush_seen && !flush_req) |=> (st_q.done_cnt == '0));

    // R8: a completion without clear moves the count by one
    a_r8_count_step: assert property (@(posedge clk) disable iff (rst)
        (done_hit && !clear) |=> (st_q.done_cnt == $past(st_q.done_cnt) + 1'b1));

endmodule

// File: rtl/desc_ring_tracker.sv
module desc_ring_tracker
    import drt_pkg::*;
#(
    parameter int                     NUM_RINGS  = 4,
    parameter logic [NUM_RINGS*5-1:0] RING_LOG2S = {5'd1, 5'd4, 5'd2, 5'd3}
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [DATA_W-1:0]     wr_data,
    input  logic                  rd_en,
    input  logic [ADDR_W-1:0]     rd_addr,
    output logic                  rd_valid,
    output logic [DATA_W-1:0]     rd_data,
    input  logic [NUM_RINGS-1:0]  fetch_go,
    input  logic                  done_valid,
    input  logic [RING_SEL_W-1:0] done_ring,
    input  logic [NUM_RINGS-1:0]  flush
);

    logic [NUM_RINGS-1:0] post_vld;
    logic [IDX_W-1:0]     post_idx;
    logic [CNT_W-1:0]     post_cnt;
    logic                 post_gen;

    logic [IDX_W-1:0] ring_head [NUM_RINGS];
    logic [CNT_W-1:0] ring_cnt  [NUM_RINGS];
    logic             ring_gen  [NUM_RINGS];
    logic [NUM_RINGS-1:0] done_hit;

    drt_post_decode #(.NUM_RINGS(NUM_RINGS)) i_dec (
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .post_vld(post_vld),
        .post_idx(post_idx),
        .post_cnt(post_cnt),
        .post_gen(post_gen)
    );

    for (genvar i = 0; i < NUM_RINGS; i++) begin : g_ring
        assign done_hit[i] = done_valid && (done_ring == RING_SEL_W'(i));

        drt_ring_slot #(.LOG2(int'(RING_LOG2S[i*5 +: 5]))) i_slot (
            .clk      (clk),
            .rst      (rst),
            .post_vld (post_vld[i]),
            .post_idx (post_idx),
            .post_cnt (post_cnt),
            .post_gen (post_gen),
            .fetch_go (fetch_go[i]),
            .done_hit (done_hit[i]),
            .flush_req(flush[i]),
            .head     (ring_head[i]),
            .done_cnt (ring_cnt[i]),
            .gen      (ring_gen[i])
        );
    end

    rd_state_t             rd_d, rd_q;
    logic [RING_SEL_W-1:0] rd_sel;
    logic                  rd_ok;

    always_comb begin
        rd_sel     = rd_addr[RING_LSB +: RING_SEL_W];
        rd_ok      = region_hit(rd_addr);
        rd_d.valid = rd_en;
        rd_d.data  = '0;
        for (int i = 0; i < NUM_RINGS; i++) begin
            if (rd_en && rd_ok && rd_sel == RING_SEL_W'(i)) begin
                rd_d.data[IDX_W-1:0]         = ring_head[i];
                rd_d.data[CNT_LSB +: CNT_W]  = ring_cnt[i];
                rd_d.data[GEN_BIT]           = ring_gen[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign rd_valid = rd_q.valid;
    assign rd_data  = rd_q.data;

    // R7: every load is answered on the next cycle
    a_r7_rd_valid: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> rd_valid);

    // R7: unused reply bits stay zero
    a_r7_rd_upper_zero: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> (rd_data[DATA_W-1:GEN_BIT+1] == '0));

    // R2: a load outside the post region reads zero
    a_r2_bad_region_zero: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !region_hit(rd_addr)) |=> (rd_data == '0));

endmodule

// File: tb/test_desc_ring_tracker.sv
module test_desc_ring_tracker;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [39:0] wr_addr = '0;
    logic [63:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [39:0] rd_addr = '0;
    logic        rd_valid;
    logic [63:0] rd_data;
    logic [3:0]  fetch_go = 4'hF;
    logic        done_valid = 1'b0;
    logic [5:0]  done_ring = '0;
    logic [3:0]  flush = '0;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    desc_ring_tracker i_desc_ring_tracker (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_en     (rd_en),
        .rd_addr   (rd_addr),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data),
        .fetch_go  (fetch_go),
        .done_valid(done_valid),
        .done_ring (done_ring),
        .flush     (flush)
    );

    // ring[55:50] idx[49:34] cnt[33:18] gen[17] exp_head[16:1] exp_gen[0]
    localparam int NVEC = 9;
    localparam logic [55:0] VEC [NVEC] = '{
        {6'd0, 16'd0,      16'd5, 1'b0, 16'd5, 1'b0},  // R3 plain post
        {6'd0, 16'd5,      16'd5, 1'b0, 16'd2, 1'b1},  // R4 across wrap
        {6'd1, 16'd0,      16'd4, 1'b0, 16'd0, 1'b1},  // R4 full ring lap
        {6'd2, 16'd3,      16'd2, 1'b0, 16'd5, 1'b0},  // R10 size 16 ring
        {6'd3, 16'd0,      16'd1, 1'b0, 16'd1, 1'b0},  // R10 size 2 ring
        {6'd3, 16'd1,      16'd3, 1'b0, 16'd1, 1'b0},  // R4 oversize ignored
        {6'd3, 16'd1,      16'd2, 1'b0, 16'd1, 1'b1},  // R4 full lap from 1
        {6'd0, 16'd4,      16'd0, 1'b1, 16'd4, 1'b1},  // R5 zero count wake
        {6'd0, 16'hFFF4,   16'd2, 1'b1, 16'd6, 1'b1}   // R3 index masked
    };

    function automatic logic [39:0] mk_addr(input int ring, input int region);
        return (40'(region) << 26) | (40'(ring) << 3);
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic post(input int ring, input logic [15:0] idx, input logic [15:0] cnt,
                        input logic g, input int region);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = mk_addr(ring, region);
        wr_data = {31'd0, g, cnt, idx};
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic load(input int ring, input int region, output logic [63:0] d, output logic v);
        @(negedge clk);
        rd_en   = 1'b1;
        rd_addr = mk_addr(ring, region);
        @(negedge clk);
        rd_en   = 1'b0;
        d = rd_data;
        v = rd_valid;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic completions(input int ring, input int n);
        @(negedge clk);
        done_ring  = 6'(ring);
        done_valid = 1'b1;
        repeat (n) @(negedge clk);
        done_valid = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        logic [63:0] d;
        logic        v;
        idle(3);
        rst = 1'b0;

        // R1 reset state on every ring
        for (int r = 0; r < 4; r++) begin
            load(r, 5, d, v);
            check("R1 reset read", d, 64'd0);
        end
        check("R7 rd_valid after load", {63'd0, v}, 64'd1);

        // table walk
        for (int k = 0; k < NVEC; k++) begin
            post(int'(VEC[k][55:50]), VEC[k][49:34], VEC[k][33:18], VEC[k][17], 5);
            idle(20);
            load(int'(VEC[k][55:50]), 5, d, v);
            check($sformatf("R3/R4/R5/R10 vector %0d head+gen", k),
                  {d[32], d[15:0]}, {47'd0, VEC[k][0], VEC[k][16:1]});
        end

        // R2 wrong region store ignored on ring 2 (head 5)
        post(2, 16'd5, 16'd3, 1'b0, 4);
        idle(10);
        load(2, 5, d, v);
        check("R2 wrong region ignored", d, 64'd5);
        // R2/R7 ring number out of range reads zero
        load(5, 5, d, v);
        check("R7 out-of-range ring reads zero", d, 64'd0);
        load(2, 3, d, v);
        check("R2 load with wrong region reads zero", d, 64'd0);

        // R6 grant pacing on ring 2
        fetch_go[2] = 1'b0;
        post(2, 16'd5, 16'd3, 1'b0, 5);
        idle(5);
        load(2, 5, d, v);
        check("R6 head holds without grant", d, 64'd5);
        @(negedge clk);
        fetch_go[2] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        fetch_go[2] = 1'b0;
        load(2, 5, d, v);
        check("R6 one step per cycle", d, 64'd7);
        fetch_go[2] = 1'b1;
        idle(5);
        load(2, 5, d, v);
        check("R6 head stops at tail", d, 64'd8);

        // R8 completion count on ring 1 (head 0, gen 1)
        completions(1, 3);
        load(1, 5, d, v);
        check("R8 three completions", d, {31'd0, 1'b1, 16'd3, 16'd0});
        load(0, 5, d, v);
        check("R10 ring 0 count unaffected", d[31:16], 64'd0);

        // R9 flush held high does not clear
        @(negedge clk);
        flush[1] = 1'b1;
        idle(2);
        load(1, 5, d, v);
        check("R9 flush high keeps count", d[31:16], 64'd3);
        // R9 falling edge with same-cycle completion: clear wins
        @(negedge clk);
        flush[1]   = 1'b0;
        done_ring  = 6'd1;
        done_valid = 1'b1;
        @(negedge clk);
        done_valid = 1'b0;
        load(1, 5, d, v);
        check("R9 clear wins over completion", d[31:16], 64'd0);
        completions(1, 1);
        load(1, 5, d, v);
        check("R9 counting resumes after clear", d[31:16], 64'd1);

        // R8 wrap of the rolling count on ring 3
        completions(3, 65537);
        load(3, 5, d, v);
        check("R8 count wraps at 16 bits", d[31:16], 64'd1);

        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule